// File: doc/BRIEF.md
# Dual-Path Socket Register Access Unit

This block holds the status and control byte registers for two card sockets, 64 bytes per socket. Host software can reach them in two ways. A memory-mapped window per socket places that socket's 64 bytes at a fixed offset inside a 4 KB region whose base software programs. A legacy index/data pair sits at one programmable I/O base: the byte at the base holds an index, and the byte just above it reads or writes the register that the index names. The index space covers socket A and then socket B, one after the other.

A single register-bus port carries memory and I/O cycles. Its address space is chosen by `bus_io`, and it has byte write data and separate read and write strobes. A small configuration port loads the two window bases and the legacy base. Every read returns data one cycle later, with a valid flag. Both paths read and write the same storage, so a byte written through one path can be read back through the other.

Top module: `sock_reg_access`

## Requirements
- R1: After reset all 128 register bytes, the index register, the two window bases and the legacy base are zero, and `rd_valid` is low.
- R2: A window base is loaded with `cfg_we` and `cfg_sel` (0 = socket A, 1 = socket B). Its low 12 bits are ignored, so the window always starts on a 4 KB boundary.
- R3: A memory cycle (`bus_io`=0) at window base + 0x800 + n, with n from 0 to 63, reaches register n of the socket that owns the window. The other socket is not affected.
- R4: A memory cycle at any other offset in a window, or at an address outside both windows, reads 0x00 and does not write anything.
- R5: The legacy base is loaded with `cfg_sel`=2 from the low `IO_W` bits of `cfg_wdata`. An I/O write (`bus_io`=1) at the legacy base loads the 8-bit index. An I/O read there returns the index.
- R6: An I/O cycle at legacy base + 1 reaches the register the index selects. Index 0x00–0x3F selects socket A register 0–63. Index 0x40–0x7F selects socket B register 0–63.
- R7: When the index is 0x80 or above, a data-port read returns 0x00 and a data-port write changes no register.
- R8: A byte written through either path reads back through the other path.
- R9: `rd_valid` is high exactly in the cycle after `bus_re`, and `rd_data` holds the read result then. When `bus_we` and `bus_re` fall in the same cycle, the read returns the value held before that write.
- R10: If both windows cover one address, socket A is accessed and socket B is left unchanged.
- R11: I/O cycles never decode a memory window, and memory cycles never decode the legacy pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 window A, 1 window B, 2 legacy base |
| cfg_wdata | input | ADDR_W | Configuration value |
| bus_io | input | 1 | Address space of the bus cycle: 1 I/O, 0 memory |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| rd_data | output | DATA_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after a read strobe |

## Verification
A read and a write can fall in the same cycle at the same register. The bench raises both strobes together at a window register that already holds a known byte. It then expects the old byte on `rd_data` in the next cycle and the new byte on a following read. It also makes the two windows overlap for one write, then separates them again and reads both sockets. Only socket A may hold the new byte.

// File: rtl/sra_pkg.sv
package sra_pkg;
   typedef enum logic [1:0] {
      CFG_WIN_A  = 2'd0,
      CFG_WIN_B  = 2'd1,
      CFG_LEGACY = 2'd2
   } cfg_sel_e;

   localparam int unsigned NUM_SOCK = 2;
endpackage

// File: rtl/sra_win_match.sv
// Decodes one socket's memory window down to its register block.
module sra_win_match #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned WIN_LG2  = 12,
   parameter int unsigned REG_OFS  = 32'h800,
   parameter int unsigned REG_LG2  = 6
) (
   input  logic [ADDR_W-1:WIN_LG2] base_hi,
   input  logic [ADDR_W-1:0]       addr,
   output logic                    reg_hit,
   output logic [REG_LG2-1:0]      reg_idx
);
   localparam logic [WIN_LG2-1:0] OFS_V = WIN_LG2'(REG_OFS);

   initial begin
      assert (REG_OFS % (2 ** REG_LG2) == 0) else $error("register offset misaligned");
      assert (REG_OFS < (2 ** WIN_LG2)) else $error("register offset outside window");
      assert (REG_LG2 < WIN_LG2) else $error("register block larger than window");
   end

   logic win_hit;
   always_comb begin
      win_hit = (addr[ADDR_W-1:WIN_LG2] == base_hi);
      reg_hit = win_hit && (addr[WIN_LG2-1:REG_LG2] == OFS_V[WIN_LG2-1:REG_LG2]);
      reg_idx = addr[REG_LG2-1:0];
   end
endmodule

// File: rtl/sra_legacy.sv
// Legacy I/O base, shared index register and its address decode.
module sra_legacy #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IO_W   = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic [IO_W-1:0]   base_wdata,
   input  logic              acc_io,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic              idx_sel,
   output logic              data_sel,
   output logic [DATA_W-1:0] index
);
   initial begin
      assert (IO_W <= ADDR_W) else $error("I/O width exceeds address width");
   end

   logic [IO_W-1:0] io_base;
   logic [IO_W-1:0] data_port;

   always_comb begin
      data_port = io_base + IO_W'(1);
      idx_sel   = acc_io && (addr == ADDR_W'(io_base));
      data_sel  = acc_io && (addr == ADDR_W'(data_port));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_base <= '0;
         index   <= '0;
      end else begin
         if (base_we) io_base <= base_wdata;
         if (idx_sel && we) index <= wdata;
      end
   end

   AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_sel && we) |=> (index == $past(wdata)));  // R5
endmodule

// File: rtl/sra_bank.sv
// Flat byte storage: slot = {socket, register}.
module sra_bank #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SLOT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SLOT_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned NSLOT = 2 ** SLOT_W;

   logic [DATA_W-1:0] mem [NSLOT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/sock_reg_access.sv
module sock_reg_access #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned IO_W    = 16,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned WIN_LG2 = 12,
   parameter int unsigned REG_OFS = 32'h800,
   parameter int unsigned REG_LG2 = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              bus_io,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   import sra_pkg::*;

   localparam int unsigned SLOT_W = REG_LG2 + 1;

   initial begin
      assert (NUM_SOCK == 2) else $error("index space assumes two sockets");
      assert (DATA_W > SLOT_W) else $error("index cannot express out-of-range values");
      assert (WIN_LG2 < ADDR_W) else $error("window larger than address space");
   end

   logic [ADDR_W-1:WIN_LG2] win_base [NUM_SOCK];
   logic [NUM_SOCK-1:0]     reg_hit;
   logic [REG_LG2-1:0]      reg_idx  [NUM_SOCK];
   cfg_sel_e                sel;

   assign sel = cfg_sel_e'(cfg_sel);

   generate
      for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) win_base[s] <= '0;
            else if (cfg_we && (sel == cfg_sel_e'(s))) win_base[s] <= cfg_wdata[ADDR_W-1:WIN_LG2];
         end

         sra_win_match #(
            .ADDR_W(ADDR_W), .WIN_LG2(WIN_LG2), .REG_OFS(REG_OFS), .REG_LG2(REG_LG2)
         ) match_i (
            .base_hi(win_base[s]),
            .addr   (bus_addr),
            .reg_hit(reg_hit[s]),
            .reg_idx(reg_idx[s])
         );
      end
   endgenerate

   logic              idx_sel, data_sel;
   logic [DATA_W-1:0] index;

   sra_legacy #(.ADDR_W(ADDR_W), .IO_W(IO_W), .DATA_W(DATA_W)) legacy_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_we   (cfg_we && (sel == CFG_LEGACY)),
      .base_wdata(cfg_wdata[IO_W-1:0]),
      .acc_io    (bus_io),
      .addr      (bus_addr),
      .we        (bus_we),
      .wdata     (bus_wdata),
      .idx_sel   (idx_sel),
      .data_sel  (data_sel),
      .index     (index)
   );

   // Decode: socket A wins an overlap; legacy port only on I/O cycles.
   logic              sel_a, sel_b, mem_hit, idx_high, lg_data, bank_we;
   logic [SLOT_W-1:0] bank_addr;
   logic [DATA_W-1:0] bank_rdata, rd_next;

   always_comb begin
      sel_a    = !bus_io && reg_hit[0];
      sel_b    = !bus_io && reg_hit[1] && !reg_hit[0];
      mem_hit  = sel_a || sel_b;
      idx_high = (index[DATA_W-1:SLOT_W] != '0);
      lg_data  = data_sel && !idx_sel && !idx_high;
      bank_addr = mem_hit ? {sel_b, (sel_b ? reg_idx[1] : reg_idx[0])} : index[SLOT_W-1:0];
      bank_we  = bus_we && (mem_hit || lg_data);
      if (idx_sel)                 rd_next = index;
      else if (mem_hit || lg_data) rd_next = bank_rdata;
      else                         rd_next = '0;
   end

   sra_bank #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) bank_i (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (bank_we),
      .addr (bank_addr),
      .wdata(bus_wdata),
      .rdata(bank_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= bus_re;
         rd_data  <= bus_re ? rd_next : '0;
      end
   end

   AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_re |=> rd_valid);  // R9
   AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> (!rd_valid && rd_data == '0));  // R9
   AST_PRIO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_io && reg_hit[0]) |-> (bank_addr[REG_LG2] == 1'b0));  // R10
   AST_HIGH_IDX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_io && data_sel && idx_high) |-> !bank_we);  // R7
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !mem_hit && !data_sel && !idx_sel) |=> (rd_data == '0));  // R4
   AST_IO_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_io && !data_sel && !idx_sel) |-> !bank_we);  // R11
endmodule

// File: tb/sock_reg_access_tb.sv
module sock_reg_access_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        bus_io = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [7:0]  rd_data;
   logic        rd_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   sock_reg_access dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
      .bus_re(bus_re), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // op: 0 cfg A, 1 cfg B, 2 cfg legacy, 3 write, 4 read
   // {op[3], io[1], addr[32], wdata[8], expect[8], req[8]}
   localparam int NV = 29;
   localparam logic [59:0] VEC [NV] = '{
      {3'd0, 1'b0, 32'h1000_0ABC, 8'h00, 8'h00, 8'd2},   // R2 low bits dropped
      {3'd1, 1'b0, 32'h2000_0000, 8'h00, 8'h00, 8'd2},
      {3'd2, 1'b0, 32'h0000_03E0, 8'h00, 8'h00, 8'd5},
      {3'd3, 1'b0, 32'h1000_0800, 8'h11, 8'h00, 8'd3},
      {3'd3, 1'b0, 32'h1000_083F, 8'h22, 8'h00, 8'd3},
      {3'd3, 1'b0, 32'h2000_0805, 8'h33, 8'h00, 8'd3},
      {3'd4, 1'b0, 32'h1000_0800, 8'h00, 8'h11, 8'd3},   // R3 socket A reg 0
      {3'd4, 1'b0, 32'h1000_083F, 8'h00, 8'h22, 8'd3},   // R3 socket A reg 63
      {3'd4, 1'b0, 32'h2000_0805, 8'h00, 8'h33, 8'd3},   // R3 socket B reg 5
      {3'd4, 1'b0, 32'h1000_0805, 8'h00, 8'h00, 8'd3},   // R3 socket A reg 5 untouched
      {3'd3, 1'b0, 32'h1000_0840, 8'h44, 8'h00, 8'd4},
      {3'd4, 1'b0, 32'h1000_0840, 8'h00, 8'h00, 8'd4},   // R4 past register block
      {3'd4, 1'b0, 32'h1000_0800, 8'h00, 8'h11, 8'd4},   // R4 reg 0 not aliased
      {3'd4, 1'b0, 32'h1000_07FF, 8'h00, 8'h00, 8'd4},   // R4 below register block
      {3'd4, 1'b0, 32'h3000_0800, 8'h00, 8'h00, 8'd4},   // R4 outside windows
      {3'd3, 1'b1, 32'h0000_03E0, 8'h3F, 8'h00, 8'd5},
      {3'd4, 1'b1, 32'h0000_03E0, 8'h00, 8'h3F, 8'd5},   // R5 index readback
      {3'd4, 1'b1, 32'h0000_03E1, 8'h00, 8'h22, 8'd8},   // R8 A reg 63 via index
      {3'd3, 1'b1, 32'h0000_03E0, 8'h45, 8'h00, 8'd6},
      {3'd4, 1'b1, 32'h0000_03E1, 8'h00, 8'h33, 8'd6},   // R6 index 0x45 -> B reg 5
      {3'd3, 1'b1, 32'h0000_03E1, 8'h5A, 8'h00, 8'd8},
      {3'd4, 1'b0, 32'h2000_0805, 8'h00, 8'h5A, 8'd8},   // R8 index write seen in window
      {3'd3, 1'b1, 32'h0000_03E0, 8'h80, 8'h00, 8'd7},
      {3'd3, 1'b1, 32'h0000_03E1, 8'h77, 8'h00, 8'd7},
      {3'd4, 1'b1, 32'h0000_03E1, 8'h00, 8'h00, 8'd7},   // R7 high index reads zero
      {3'd3, 1'b1, 32'h0000_03E0, 8'h00, 8'h00, 8'd7},
      {3'd4, 1'b1, 32'h0000_03E1, 8'h00, 8'h11, 8'd7},   // R7 reg 0 kept its value
      {3'd4, 1'b1, 32'h1000_0800, 8'h00, 8'h00, 8'd11},  // R11 I/O cycle at window address
      {3'd4, 1'b0, 32'h0000_03E1, 8'h00, 8'h00, 8'd11}   // R11 memory cycle at data port
   };

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
      checks++;
      if (act !== exp || rd_valid !== 1'b1) begin
         fails++;
         $display("FAIL R%0d: rd_data=%02h valid=%b expected %02h valid=1", req, act, rd_valid, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] s, input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic access(input logic io, input logic [31:0] a, input logic w, input logic r,
                         input logic [7:0] d);
      @(negedge clk);
      bus_io = io; bus_addr = a; bus_we = w; bus_re = r; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_re = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state seen through the ports
      checks++;
      if (rd_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1: rd_valid=%b expected 0", rd_valid);
      end
      access(1'b0, 32'h0000_0800, 1'b0, 1'b1, 8'h00); check(rd_data, 8'h00, 1);  // R1 window at 0
      access(1'b1, 32'h0000_0000, 1'b0, 1'b1, 8'h00); check(rd_data, 8'h00, 1);  // R1 index zero
      access(1'b1, 32'h0000_0001, 1'b0, 1'b1, 8'h00); check(rd_data, 8'h00, 1);  // R1 data port

      for (int i = 0; i < NV; i++) begin
         logic [2:0] op;
         op = VEC[i][59:57];
         case (op)
            3'd0, 3'd1, 3'd2: cfg(op[1:0], VEC[i][55:24]);
            3'd3: access(VEC[i][56], VEC[i][55:24], 1'b1, 1'b0, VEC[i][23:16]);
            default: begin
               access(VEC[i][56], VEC[i][55:24], 1'b0, 1'b1, 8'h00);
               check(rd_data, VEC[i][15:8], int'(VEC[i][7:0]));
            end
         endcase
      end

      // R9: read and write together return the old byte
      access(1'b0, 32'h1000_0800, 1'b1, 1'b1, 8'hC3); check(rd_data, 8'h11, 9);
      access(1'b0, 32'h1000_0800, 1'b0, 1'b1, 8'h00); check(rd_data, 8'hC3, 9);
      // R9: no strobe, no valid
      @(negedge clk);
      checks++;
      if (rd_valid !== 1'b0 || rd_data !== 8'h00) begin
         fails++;
         $display("FAIL R9: idle rd_valid=%b rd_data=%02h expected 0/00", rd_valid, rd_data);
      end

      // R10: overlapping windows, socket A takes the write
      cfg(2'd1, 32'h1000_0000);
      access(1'b0, 32'h1000_0810, 1'b1, 1'b0, 8'h99);
      cfg(2'd1, 32'h2000_0000);
      access(1'b0, 32'h2000_0810, 1'b0, 1'b1, 8'h00); check(rd_data, 8'h00, 10);
      access(1'b0, 32'h1000_0810, 1'b0, 1'b1, 8'h00); check(rd_data, 8'h99, 10);
      // R2: moving the base to another 4 KB page follows the upper bits only
      cfg(2'd0, 32'h1234_5FFF);
      access(1'b0, 32'h1234_5810, 1'b0, 1'b1, 8'h00); check(rd_data, 8'h99, 2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule